// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

The block has two 16-bit count channels. Each channel is a low byte and a high byte. A four-bit configuration nibble controls each channel: a gate-qualify bit, a source select bit (internal machine-cycle tick or an external pin) and a two-bit mode. Each channel also has a run bit and an overflow flag. The count source is either the `tick` strobe, which fires once per machine cycle, or the falling transitions of the channel's count pin. The pin is sampled on each tick.

The mode picks the counter shape. Mode 0 is a 13-bit counter: a 5-bit prescaler in the low byte feeds the high byte. Mode 1 is a full 16-bit counter. Mode 2 is an 8-bit counter that reloads from the high byte. Mode 3, on channel 0, splits the channel into two 8-bit counters, and the high one takes channel 1's run bit and flag. Registers are loaded through a one-cycle write port. The flags are cleared by per-flag clear strobes, for example from a service acknowledge. Every channel-1 overflow also produces a one-clock pulse that can drive a baud-rate generator.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both counts, the configuration, the run bits, both flags and `baud_pulse` are 0.
- R2: A channel's count event is accepted only when its run bit is 1 and either its gate bit is 0 or its `gate_pin` bit is 1. Otherwise the count holds.
- R3: With source select 0, a channel advances once per `tick`. With source select 1, it advances once for each tick at which the pin samples 0 after it sampled 1 at the previous tick. A steady pin gives no counts.
- R4: Mode 0 (code 00) counts in bits [4:0] of the low byte. Wrapping them from 31 increments the high byte. Low-byte bits [7:5] keep their written value. Overflow is high byte FF with prescaler 31.
- R5: Mode 1 (code 01) counts {high,low} as one 16-bit value and overflows from FFFF to 0000.
- R6: Mode 2 (code 10) counts the low byte only. When the low byte is FF, the next event loads it from the high byte, the high byte is unchanged, and overflow is signalled.
- R7: An overflow sets the channel's flag in `ovf_flag` (bit 0 for channel 0, bit 1 for channel 1) at the same clock edge. The flag stays set until it is cleared.
- R8: A 1 on `flag_clr[i]` clears flag i. A write to the control register (address 5) loads run0 from bit 0, run1 from bit 1, flag0 from bit 2 and flag1 from bit 3. In the same cycle, a control write takes precedence over an overflow, and an overflow takes precedence over a clear.
- R9: In mode 3 (code 11), channel 0's low byte is an 8-bit counter that uses channel 0's gate, source, run bit and flag.
- R10: In mode 3, channel 0's high byte counts ticks whenever run1 is 1, with no gate. Its wrap from FF sets flag 1.
- R11: While channel 0 is in mode 3, channel 1 counts without its run bit (gate still applies), and its overflows do not set flag 1. Channel 1 set to code 11 holds its count.
- R12: `baud_pulse` is high for exactly one clock, one clock after each channel-1 overflow.
- R13: Write addresses are 0 low0, 1 high0, 2 low1, 3 high1, 4 configuration, 5 control. The configuration byte holds channel 0 in bits [3:0] and channel 1 in bits [7:4], each as {gate, source, mode[1:0]}. A register write takes precedence over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count pin per channel |
| gate_pin | input | 2 | External gate pin per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W | Register write data |
| flag_clr | input | 2 | Per-flag clear strobe |
| cnt0_q | output | 2*W | Channel 0 count {high,low} |
| cnt1_q | output | 2*W | Channel 1 count {high,low} |
| ovf_flag | output | 2 | Overflow flags |
| baud_pulse | output | 1 | Channel-1 overflow pulse |

## Verification
A wrong mode decode or carry path shows up on the count outputs at the first tick after the mistake. It then stays wrong, because each later count builds on the bad value. A wrong flag owner in split mode shows up on `ovf_flag` in the same cycle as the wrap, and wrap points are reached within a few ticks from preloaded values. Pin-sampling faults show up as the wrong number of counts after a short pin pattern. Baud-pulse width faults show up as the wrong pulse total over three reload periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MD_PRE13   = 2'd0,
        MD_FULL16  = 2'd1,
        MD_RELOAD8 = 2'd2,
        MD_SPLIT   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext;
        tmr_mode_e mode;
    } tmr_cfg_t;

    localparam int unsigned CFG_W = 4;

    localparam logic [2:0] A_LO0  = 3'd0;
    localparam logic [2:0] A_HI0  = 3'd1;
    localparam logic [2:0] A_LO1  = 3'd2;
    localparam logic [2:0] A_HI1  = 3'd3;
    localparam logic [2:0] A_CFG  = 3'd4;
    localparam logic [2:0] A_CTRL = 3'd5;
endpackage

// File: rtl/tmr_pinsamp.sv
module tmr_pinsamp #(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [NCH-1:0] pin,
    output logic [NCH-1:0] fall
);
    logic [NCH-1:0] smp_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n)    smp_q[i] <= 1'b0;
            else if (tick) smp_q[i] <= pin[i];
        end

        assign fall[i] = tick & smp_q[i] & ~pin[i];

        // R3: one falling transition can not yield two counts
        a_r3_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !fall[i]);
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
    parameter int unsigned W         = 8,
    parameter int unsigned PRE       = 5,
    parameter bit          CAN_SPLIT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_mode_e    mode,
    input  logic         inc,
    input  logic         hi_inc,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q,
    output logic         ovf,
    output logic         hi_ovf
);
    localparam logic [W-1:0]   ONES = '1;
    localparam logic [PRE-1:0] PMAX = '1;

    logic [W-1:0] lo_n, hi_n;

    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        ovf    = 1'b0;
        hi_ovf = 1'b0;
        unique case (mode)
            MD_PRE13: if (inc) begin
                lo_n[PRE-1:0] = lo_q[PRE-1:0] + 1'b1;
                if (lo_q[PRE-1:0] == PMAX) begin
                    hi_n = hi_q + 1'b1;
                    ovf  = (hi_q == ONES);
                end
            end
            MD_FULL16: if (inc) begin
                {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
                ovf          = (lo_q == ONES) && (hi_q == ONES);
            end
            MD_RELOAD8: if (inc) begin
                if (lo_q == ONES) begin
                    lo_n = hi_q;
                    ovf  = 1'b1;
                end else begin
                    lo_n = lo_q + 1'b1;
                end
            end
            MD_SPLIT: if (CAN_SPLIT) begin
                if (inc) begin
                    lo_n = lo_q + 1'b1;
                    ovf  = (lo_q == ONES);
                end
                if (hi_inc) begin
                    hi_n   = hi_q + 1'b1;
                    hi_ovf = (hi_q == ONES);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= wr_lo ? wr_data : lo_n;
            hi_q <= wr_hi ? wr_data : hi_n;
        end
    end

    // R2: no event and no write keeps both bytes
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !hi_inc && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
    // R4: prescaler mode leaves the top low-byte bits alone
    a_r4_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PRE13 && !wr_lo) |=> (lo_q[W-1:PRE] == $past(lo_q[W-1:PRE])));
    // R5: cascaded mode adds one per event
    a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_FULL16 && inc && !wr_lo && !wr_hi)
            |=> ({hi_q, lo_q} == $past({hi_q, lo_q}) + 1'b1));
    // R6: reload takes the high byte and keeps it
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RELOAD8 && inc && lo_q == ONES && !wr_lo && !wr_hi)
            |=> (lo_q == $past(hi_q) && $stable(hi_q)));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pkg::*; #(
    parameter int unsigned W   = 8,
    parameter int unsigned PRE = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [1:0]     cnt_pin,
    input  logic [1:0]     gate_pin,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic [1:0]     flag_clr,
    output logic [2*W-1:0] cnt0_q,
    output logic [2*W-1:0] cnt1_q,
    output logic [1:0]     ovf_flag,
    output logic           baud_pulse
);
    localparam int unsigned NCH = 2;

    logic [NCH*CFG_W-1:0] cfg_q;
    logic [NCH-1:0]       run_q, flag_q, fall, gate_ok, src, en;
    logic                 baud_q, split, hi_inc0;
    logic                 wr_cfg, wr_ctrl;
    logic                 ovf0, hov0, ovf1, hov1;
    logic [NCH-1:0]       set_f;
    logic [W-1:0]         lo0, hi0, lo1, hi1;
    tmr_cfg_t             cfg [NCH];

    assign wr_cfg  = wr_en && (wr_addr == A_CFG);
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

    tmr_pinsamp #(.NCH(NCH)) u_samp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin), .fall(fall)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_src
        assign cfg[i]     = tmr_cfg_t'(cfg_q[CFG_W*i +: CFG_W]);
        assign gate_ok[i] = ~cfg[i].gate | gate_pin[i];
        assign src[i]     = cfg[i].ext ? fall[i] : tick;
    end

    assign split   = (cfg[0].mode == MD_SPLIT);
    assign en[0]   = run_q[0] & gate_ok[0] & src[0];
    assign en[1]   = (split | run_q[1]) & gate_ok[1] & src[1];
    assign hi_inc0 = split & run_q[1] & tick;

    tmr_chan #(.W(W), .PRE(PRE), .CAN_SPLIT(1'b1)) u_ch0 (
        .clk(clk), .rst_n(rst_n), .mode(cfg[0].mode), .inc(en[0]), .hi_inc(hi_inc0),
        .wr_lo(wr_en && wr_addr == A_LO0), .wr_hi(wr_en && wr_addr == A_HI0),
        .wr_data(wr_data), .lo_q(lo0), .hi_q(hi0), .ovf(ovf0), .hi_ovf(hov0)
    );

    tmr_chan #(.W(W), .PRE(PRE), .CAN_SPLIT(1'b0)) u_ch1 (
        .clk(clk), .rst_n(rst_n), .mode(cfg[1].mode), .inc(en[1]), .hi_inc(1'b0),
        .wr_lo(wr_en && wr_addr == A_LO1), .wr_hi(wr_en && wr_addr == A_HI1),
        .wr_data(wr_data), .lo_q(lo1), .hi_q(hi1), .ovf(ovf1), .hi_ovf(hov1)
    );

    assign set_f[0] = ovf0;
    assign set_f[1] = split ? hov0 : (ovf1 | hov1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            run_q  <= '0;
            flag_q <= '0;
            baud_q <= 1'b0;
        end else begin
            if (wr_cfg) cfg_q <= wr_data[NCH*CFG_W-1:0];
            if (wr_ctrl) begin
                run_q  <= wr_data[1:0];
                flag_q <= wr_data[3:2];
            end else begin
                for (int i = 0; i < NCH; i++) begin
                    if (set_f[i])         flag_q[i] <= 1'b1;
                    else if (flag_clr[i]) flag_q[i] <= 1'b0;
                end
            end
            baud_q <= ovf1;
        end
    end

    assign cnt0_q     = {hi0, lo0};
    assign cnt1_q     = {hi1, lo1};
    assign ovf_flag   = flag_q;
    assign baud_pulse = baud_q;

    // R7: channel 0 overflow raises its flag
    a_r7_flag0_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf0 && !wr_ctrl) |=> ovf_flag[0]);
    // R10: split high byte wrap raises flag 1
    a_r10_split_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (split && hov0 && !wr_ctrl) |=> ovf_flag[1]);
    // R8: clear strobe without competing set drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[0] && !ovf0 && !wr_ctrl) |=> !ovf_flag[0]);
    // R11: channel 1 wraps leave flag 1 alone during split
    a_r11_no_ch1_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !hov0 && !wr_ctrl && !flag_clr[1]) |=> $stable(ovf_flag[1]));
    // R12: the pulse follows a tick and lasts one clock
    a_r12_baud_tick: assert property (@(posedge clk) disable iff (!rst_n)
        baud_pulse |-> $past(tick));
endmodule

// File: tb/tb_tmr_pair.sv
`timescale 1ns/1ps
module tb_tmr_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  cnt_pin = 2'b00;
    logic [1:0]  gate_pin = 2'b00;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [1:0]  flag_clr = 2'b00;
    logic [15:0] cnt0_q, cnt1_q;
    logic [1:0]  ovf_flag;
    logic        baud_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tmr_pair dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .flag_clr(flag_clr),
        .cnt0_q(cnt0_q), .cnt1_q(cnt1_q), .ovf_flag(ovf_flag), .baud_pulse(baud_pulse)
    );

    typedef struct packed {
        logic [7:0] md;
        logic [7:0] tl;
        logic [7:0] th;
        logic [7:0] n;
        logic [7:0] etl;
        logic [7:0] eth;
        logic       ef;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'hF0, 8'h12, 8'd32, 8'h10, 8'h13, 1'b0, 4'd5},  // R5 carry into high
        '{8'h01, 8'hFE, 8'hFF, 8'd3,  8'h01, 8'h00, 1'b1, 4'd5},  // R5 R7 wrap
        '{8'h00, 8'hE0, 8'h05, 8'd33, 8'hE1, 8'h06, 1'b0, 4'd4},  // R4 prescale
        '{8'h00, 8'h5F, 8'hFF, 8'd2,  8'h41, 8'h00, 1'b1, 4'd4},  // R4 R7 wrap
        '{8'h02, 8'hFD, 8'hC0, 8'd3,  8'hC0, 8'hC0, 1'b1, 4'd6},  // R6 reload
        '{8'h02, 8'hFE, 8'h80, 8'd5,  8'h83, 8'h80, 1'b1, 4'd6},  // R6 after reload
        '{8'h03, 8'hFF, 8'h10, 8'd2,  8'h01, 8'h10, 1'b1, 4'd9},  // R9 split low
        '{8'h09, 8'h00, 8'h00, 8'd10, 8'h00, 8'h00, 1'b0, 4'd2}   // R2 gate closed
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        logic [6:0] seq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt0", cnt0_q, 16'h0);
        chk("R1 cnt1", cnt1_q, 16'h0);
        chk("R1 flags+baud", {13'd0, ovf_flag, baud_pulse}, 16'h0);

        for (int v = 0; v < NV; v++) begin
            wr(3'd5, 8'h00);
            wr(3'd4, VECS[v].md);
            wr(3'd0, VECS[v].tl);
            wr(3'd1, VECS[v].th);
            wr(3'd5, 8'h01);
            run_ticks(int'(VECS[v].n));
            chk($sformatf("R%0d vec%0d count", VECS[v].rq, v), cnt0_q, {VECS[v].eth, VECS[v].etl});
            chk($sformatf("R%0d vec%0d flag0", VECS[v].rq, v), {15'd0, ovf_flag[0]}, {15'd0, VECS[v].ef});
        end

        // R3 counter source: falling transitions only
        wr(3'd5, 8'h00); wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd5, 8'h01);
        seq = 7'b0100101;  // applied LSB first: 1,0,1,0,0,1,0
        @(negedge clk);
        tick = 1'b1;
        for (int k = 0; k < 7; k++) begin
            cnt_pin[0] = seq[k];
            @(negedge clk);
        end
        cnt_pin[0] = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        chk("R3 pin falls", cnt0_q, 16'h0003);

        // R2 gate open
        cnt_pin[0] = 1'b0;
        wr(3'd5, 8'h00); wr(3'd4, 8'h09); wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd5, 8'h01);
        gate_pin[0] = 1'b1;
        run_ticks(4);
        gate_pin[0] = 1'b0;
        chk("R2 gate open", cnt0_q, 16'h0004);

        // R10 R11 split mode
        wr(3'd5, 8'h00); wr(3'd4, 8'h13); wr(3'd0, 8'h00); wr(3'd1, 8'hFE);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h03);
        run_ticks(3);
        chk("R10 split cnt0", cnt0_q, 16'h0103);
        chk("R10 flag1", {14'd0, ovf_flag}, 16'h0002);
        chk("R11 ch1 counts", cnt1_q, 16'h0003);
        wr(3'd5, 8'h01);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        run_ticks(2);
        chk("R10 high needs run1", cnt0_q, 16'h0105);
        chk("R11 ch1 without run", cnt1_q, 16'h0001);
        chk("R11 ch1 wrap no flag", {15'd0, ovf_flag[1]}, 16'h0);

        // R8 software write and clear strobe
        wr(3'd5, 8'h04);
        chk("R8 sw set", {14'd0, ovf_flag}, 16'h0001);
        @(negedge clk); flag_clr[0] = 1'b1;
        @(negedge clk); flag_clr[0] = 1'b0;
        chk("R8 clear", {14'd0, ovf_flag}, 16'h0000);

        // R12 baud pulse on channel 1 reload
        wr(3'd5, 8'h00); wr(3'd4, 8'h20); wr(3'd2, 8'hFD); wr(3'd3, 8'hFD); wr(3'd5, 8'h02);
        pulses = 0;
        @(negedge clk);
        tick = 1'b1;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (baud_pulse) pulses++;
        end
        tick = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            if (baud_pulse) pulses++;
        end
        chk("R12 pulses", 16'(pulses), 16'd3);
        chk("R7 flag1", {15'd0, ovf_flag[1]}, 16'h1);
        chk("R6 ch1 reload", cnt1_q, 16'hFDFD);

        // R11 channel 1 in code 11 holds
        wr(3'd5, 8'h00); wr(3'd4, 8'h31); wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd5, 8'h02);
        run_ticks(4);
        chk("R11 ch1 hold", cnt1_q, 16'h3412);

        // R13 address map
        wr(3'd5, 8'h00);
        wr(3'd0, 8'hA5); wr(3'd1, 8'h5A);
        chk("R13 map", cnt0_q, 16'h5AA5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule